// File: doc/BRIEF.md
# Fixed-Window Fractional Accumulator

This block produces one output sample of a short-memory fractional-order operator for each input sample it takes in. Every accepted sample is stored in a circular history. The block then takes the weighted sum of the newest samples, using an externally stored coefficient table, one multiply-accumulate per clock. The sum is multiplied by a step-size factor, rounded, saturated and presented with a one-cycle valid strobe.

The same datapath serves fractional integration and fractional differentiation: only the coefficient set and the scale factor differ, and they are supplied from outside. The caller also chooses the window length per sample, up to the history depth (1024 by default). While a result is being formed the block refuses new samples by holding `smp_ready_o` low.

Top module: `fracwin_core`

## Requirements
- R1: While reset is held and after it is released, `smp_ready_o` is 1, `res_valid_o` is 0 and `res_data_o` is 0.
- R2: A sample is taken on a clock edge where `smp_valid_i` and `smp_ready_o` are both 1. `smp_ready_o` then stays 0 until the result for that sample is presented. A sample offered while `smp_ready_o` is 0 is kept waiting and is taken afterwards, unaltered.
- R3: With N effective terms, `res_valid_o` is 1 for exactly one cycle, N+2 clock edges after the acceptance edge.
- R4: Samples are signed 32-bit with 24 fraction bits. Term j (j = 0 … N-1) multiplies coefficient j by the sample accepted j acceptances before the current one. Term 0 uses the sample just accepted.
- R5: A term whose sample position is older than the oldest stored sample contributes zero. This applies until the history has filled.
- R6: Coefficients are signed 24-bit with 20 fraction bits. Each product is shifted right arithmetically by 20 bits, which truncates toward minus infinity to 24 fraction bits. The shifted products are summed in a 48-bit accumulator.
- R7: The scale factor is signed 32-bit with 24 fraction bits. The result is round(sum × scale) to 24 fraction bits, with exact halves rounded toward plus infinity.
- R8: A result above 0x7FFFFFFF is output as 0x7FFFFFFF. A result below 0x80000000 (as a signed value) is output as 0x80000000.
- R9: The scale factor is taken on the acceptance edge. Changes on `scale_i` during the computation have no effect on the result.
- R10: The window length is taken on the acceptance edge. A value of 0 yields a result of 0 after 2 edges. A value above the history depth is treated as the history depth.
- R11: The history is circular. Once more samples than its depth have arrived, the oldest is overwritten, and a full-depth window uses exactly the newest depth samples.
- R12: `coef_addr_o` steps through 0, 1, … N-1, one address per cycle, starting in the cycle after acceptance. `coef_data_i` must carry the entry for the address presented on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Input sample offered |
| smp_data_i | input | 32 | Input sample, signed, 24 fraction bits |
| smp_ready_o | output | 1 | Block can take a sample |
| win_len_i | input | clog2(DEPTH+1)+1 | Number of terms for this sample |
| scale_i | input | 32 | Step-size factor, signed, 24 fraction bits |
| coef_addr_o | output | clog2(DEPTH) | Coefficient index requested |
| coef_data_i | input | 24 | Coefficient for previous address, signed, 20 fraction bits |
| res_valid_o | output | 1 | Result strobe, one cycle |
| res_data_o | output | 32 | Result, signed, 24 fraction bits, saturated |

## Verification
The bench builds the block with a history depth of 16 and keeps every other parameter at its default. At that depth, a few tens of samples are enough to fill the history and wrap it. A window request above the depth shows the clamp. A window of the full depth reaches back past the overwritten entries. The default widths keep the bench's arithmetic model close to the formats stated in the requirements.

// File: rtl/fracwin_pkg.sv
package fracwin_pkg;

  // Sequencer phases of one output computation.
  typedef enum logic [1:0] {
    FW_IDLE   = 2'd0,
    FW_ISSUE  = 2'd1,
    FW_DRAIN  = 2'd2,
    FW_FINISH = 2'd3
  } fw_state_e;

endpackage

// File: rtl/fracwin_hist.sv
module fracwin_hist #(
  parameter int DEPTH = 1024,
  parameter int SMP_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [SMP_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_ofs_i,
  output logic [SMP_W-1:0] rd_data_o,
  output logic             rd_live_o
);

  logic [SMP_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, wp_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic [AW-1:0]    rd_idx;
  logic             live_d, live_q;
  logic [SMP_W-1:0] rd_q;

  // Next state: write pointer, fill level, read index.
  always_comb begin
    wp_d  = wp_q;
    cnt_d = cnt_q;
    if (wr_en_i) begin
      wp_d = wp_q + AW'(1);
      if (cnt_q != (AW+1)'(DEPTH)) cnt_d = cnt_q + (AW+1)'(1);
    end
    // newest entry sits one below the write pointer
    rd_idx = wp_q - AW'(1) - rd_ofs_i;
    live_d = ({1'b0, rd_ofs_i} < cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
      if (rd_en_i) live_q <= live_d;
    end
  end

  // Storage array, no reset.
  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wp_q] <= wr_data_i;
    if (rd_en_i) rd_q <= mem_q[rd_idx];
  end

  assign rd_data_o = rd_q;
  assign rd_live_o = live_q;

  // R11
  hist_fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));

endmodule

// File: rtl/fracwin_ctrl.sv
module fracwin_ctrl
  import fracwin_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int SCALE_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid_i,
  input  logic [LEN_W-1:0]   win_len_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               ready_o,
  output logic               accept_o,
  output logic               issue_o,
  output logic [AW-1:0]      term_o,
  output logic               finish_o,
  output logic [SCALE_W-1:0] scale_o
);

  fw_state_e          state_q, state_d;
  logic [AW-1:0]      term_q, term_d;
  logic [LEN_W-1:0]   nterms_q, nterms_d;
  logic [SCALE_W-1:0] scale_q, scale_d;
  logic [LEN_W-1:0]   eff_len;

  always_comb begin
    eff_len  = (win_len_i > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : win_len_i;
    state_d  = state_q;
    term_d   = term_q;
    nterms_d = nterms_q;
    scale_d  = scale_q;
    case (state_q)
      FW_IDLE: begin
        if (in_valid_i) begin
          nterms_d = eff_len;
          scale_d  = scale_i;
          term_d   = '0;
          state_d  = (eff_len == '0) ? FW_DRAIN : FW_ISSUE;
        end
      end
      FW_ISSUE: begin
        term_d = term_q + AW'(1);
        if (LEN_W'(term_q) == nterms_q - LEN_W'(1)) state_d = FW_DRAIN;
      end
      FW_DRAIN:  state_d = FW_FINISH;
      FW_FINISH: state_d = FW_IDLE;
      default:   state_d = FW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FW_IDLE;
      term_q   <= '0;
      nterms_q <= '0;
      scale_q  <= '0;
    end else begin
      state_q  <= state_d;
      term_q   <= term_d;
      nterms_q <= nterms_d;
      scale_q  <= scale_d;
    end
  end

  assign ready_o  = (state_q == FW_IDLE);
  assign accept_o = ready_o && in_valid_i;
  assign issue_o  = (state_q == FW_ISSUE);
  assign finish_o = (state_q == FW_FINISH);
  assign term_o   = term_q;
  assign scale_o  = scale_q;

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && ready_o) |=> !ready_o);

  // R12
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && $past(issue_o)) |-> (term_o == $past(term_o) + AW'(1)));

  // R9
  scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != FW_IDLE) && $past(state_q != FW_IDLE)) |-> $stable(scale_q));

  // R10
  win_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nterms_q <= LEN_W'(DEPTH));

endmodule

// File: rtl/fracwin_mac.sv
module fracwin_mac #(
  parameter int SMP_W     = 32,
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 20,
  parameter int ACC_W     = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    issue_i,
  input  logic                    live_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0] acc_o
);

  localparam int PRD_W = SMP_W + COEF_W;

  logic                    pend_q;
  logic signed [PRD_W-1:0] prod;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    prod  = smp_i * coef_i;
    term  = ACC_W'(prod >>> COEF_FRAC);
    acc_d = acc_q;
    if (clear_i)               acc_d = '0;
    else if (pend_q && live_i) acc_d = acc_q + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      pend_q <= issue_i;
      acc_q  <= acc_d;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/fracwin_scale.sv
module fracwin_scale #(
  parameter int ACC_W      = 48,
  parameter int SCALE_W    = 32,
  parameter int SCALE_FRAC = 24,
  parameter int OUT_W      = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire_i,
  input  logic signed [ACC_W-1:0]   acc_i,
  input  logic signed [SCALE_W-1:0] scale_i,
  output logic [OUT_W-1:0]          data_o,
  output logic                      valid_o
);

  localparam int PW = ACC_W + SCALE_W + 1;
  localparam logic signed [PW-1:0] HALF   = PW'(1) <<< (SCALE_FRAC - 1);
  localparam logic signed [PW-1:0] SAT_HI = (PW'(1) <<< (OUT_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] SAT_LO = -(PW'(1) <<< (OUT_W - 1));

  logic signed [PW-1:0] prod_w, rnd_w;
  logic [OUT_W-1:0]     sat_w;
  logic [OUT_W-1:0]     data_q;
  logic                 valid_q;

  always_comb begin
    prod_w = acc_i * scale_i;
    rnd_w  = (prod_w + HALF) >>> SCALE_FRAC;
    if (rnd_w > SAT_HI)      sat_w = SAT_HI[OUT_W-1:0];
    else if (rnd_w < SAT_LO) sat_w = SAT_LO[OUT_W-1:0];
    else                     sat_w = rnd_w[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= fire_i;
      if (fire_i) data_q <= sat_w;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R3
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

endmodule

// File: rtl/fracwin_core.sv
module fracwin_core #(
  parameter int DEPTH      = 1024,
  parameter int SMP_W      = 32,
  parameter int COEF_W     = 24,
  parameter int COEF_FRAC  = 20,
  parameter int ACC_W      = 48,
  parameter int SCALE_W    = 32,
  parameter int SCALE_FRAC = 24,
  parameter int OUT_W      = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid_i,
  input  logic [SMP_W-1:0]   smp_data_i,
  output logic               smp_ready_o,
  input  logic [LEN_W-1:0]   win_len_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [AW-1:0]      coef_addr_o,
  input  logic [COEF_W-1:0]  coef_data_i,
  output logic               res_valid_o,
  output logic [OUT_W-1:0]   res_data_o
);

  logic               accept, issue, finish, live;
  logic [AW-1:0]      term;
  logic [SCALE_W-1:0] scale_q;
  logic [SMP_W-1:0]   hist_smp;
  logic [ACC_W-1:0]   acc;

  fracwin_ctrl #(.DEPTH(DEPTH), .SCALE_W(SCALE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (smp_valid_i),
    .win_len_i  (win_len_i),
    .scale_i    (scale_i),
    .ready_o    (smp_ready_o),
    .accept_o   (accept),
    .issue_o    (issue),
    .term_o     (term),
    .finish_o   (finish),
    .scale_o    (scale_q)
  );

  fracwin_hist #(.DEPTH(DEPTH), .SMP_W(SMP_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (accept),
    .wr_data_i (smp_data_i),
    .rd_en_i   (issue),
    .rd_ofs_i  (term),
    .rd_data_o (hist_smp),
    .rd_live_o (live)
  );

  fracwin_mac #(.SMP_W(SMP_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .ACC_W(ACC_W)) u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .issue_i (issue),
    .live_i  (live),
    .smp_i   (hist_smp),
    .coef_i  (coef_data_i),
    .acc_o   (acc)
  );

  fracwin_scale #(.ACC_W(ACC_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC), .OUT_W(OUT_W)) u_scale (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (finish),
    .acc_i   (acc),
    .scale_i (scale_q),
    .data_o  (res_data_o),
    .valid_o (res_valid_o)
  );

  assign coef_addr_o = term;

endmodule

// File: tb/fracwin_core_tb.sv
`timescale 1ns/1ps
module fracwin_core_tb;

  localparam int DEP = 16;
  localparam int AW  = $clog2(DEP);
  localparam int LW  = $clog2(DEP + 1) + 1;

  logic               clk;
  logic               rst_n;
  logic               smp_valid;
  logic signed [31:0] smp_data;
  logic               smp_ready;
  logic [LW-1:0]      win_len;
  logic signed [31:0] scale;
  logic [AW-1:0]      coef_addr;
  logic signed [23:0] coef_q;
  logic               res_valid;
  logic signed [31:0] res_data;

  logic signed [23:0] ctab [DEP];
  logic signed [31:0] bhist [4096];
  int bn = 0;
  int tests = 0;
  int fails = 0;

  fracwin_core #(.DEPTH(DEP)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid_i (smp_valid),
    .smp_data_i  (smp_data),
    .smp_ready_o (smp_ready),
    .win_len_i   (win_len),
    .scale_i     (scale),
    .coef_addr_o (coef_addr),
    .coef_data_i (coef_q),
    .res_valid_o (res_valid),
    .res_data_o  (res_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // coefficient store with one-cycle read
  always @(posedge clk) coef_q <= ctab[coef_addr];

  function automatic logic signed [31:0] sq(input real r);
    return 32'(longint'(r * 16777216.0));
  endfunction

  function automatic logic signed [23:0] cf(input real r);
    return 24'(longint'(r * 1048576.0));
  endfunction

  function automatic logic signed [31:0] model(input int n, input logic signed [31:0] sc);
    longint acc;
    logic signed [95:0] a96, s96, big;
    acc = 0;
    for (int j = 0; j < n; j++) begin
      if (j < bn) begin
        longint p;
        p = longint'(bhist[bn-1-j]) * longint'(ctab[j]);
        acc = acc + (p >>> 20);
      end
    end
    a96 = acc;
    s96 = sc;
    big = a96 * s96 + 96'sd8388608;
    big = big >>> 24;
    if (big > 96'sd2147483647) return 32'h7FFFFFFF;
    if (big < -96'sd2147483648) return 32'h80000000;
    return big[31:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_coefs();
    for (int i = 0; i < DEP; i++) ctab[i] = '0;
  endtask

  // one sample through the block, checking R3/R12/R2 timing and value
  task automatic run(input logic signed [31:0] s, input int n, input logic signed [31:0] sc,
                     input logic signed [31:0] sc_late, input string tag,
                     output logic signed [31:0] res);
    int neff, lat, pulses;
    bit addr_ok;
    logic signed [31:0] exp;
    neff = (n > DEP) ? DEP : n;
    @(negedge clk);
    win_len = LW'(n);
    scale = sc;
    smp_data = s;
    smp_valid = 1'b1;
    @(posedge clk);
    bhist[bn] = s;
    bn++;
    exp = model(neff, sc);
    lat = -1;
    pulses = 0;
    addr_ok = 1'b1;
    res = '0;
    for (int m = 0; m < DEP + 8; m++) begin
      @(negedge clk);
      if (m == 0) begin
        smp_valid = 1'b0;
        chk(!smp_ready, "R2 ready low after take", smp_ready, 0);
      end
      if (m == 1) scale = sc_late;
      if (m < neff && coef_addr != AW'(m)) addr_ok = 1'b0;
      if (res_valid) begin
        pulses++;
        if (lat < 0) begin
          lat = m;
          res = res_data;
        end
      end
    end
    chk(addr_ok, "R12 coefficient address order", addr_ok, 1);
    chk(lat == neff + 2, "R3 result latency", lat, neff + 2);
    chk(pulses == 1, "R3 single strobe", pulses, 1);
    chk(res == exp, tag, res, exp);
  endtask

  task automatic t_reset();
    chk(smp_ready == 1'b1, "R1 ready after reset", smp_ready, 1);
    chk(res_valid == 1'b0, "R1 valid after reset", res_valid, 0);
    chk(res_data == '0, "R1 data after reset", res_data, 0);
  endtask

  task automatic t_fill_and_pairing();
    logic signed [31:0] r;
    clear_coefs();
    ctab[0] = cf(1.0); ctab[1] = cf(0.5); ctab[2] = cf(0.375); ctab[3] = cf(0.3125);
    run(sq(1.5), 4, sq(1.0), sq(1.0), "R5 zero before fill", r);
    chk(r == sq(1.5), "R5 first sample only", r, sq(1.5));
    run(sq(2.0), 4, sq(1.0), sq(1.0), "R4 two terms", r);
    chk(r == sq(2.75), "R4 newest paired with coef 0", r, sq(2.75));
    run(sq(-0.25), 4, sq(1.0), sq(1.0), "R4 integrating set", r);
    run(sq(0.75), 4, sq(1.0), sq(1.0), "R4 integrating set full", r);
    ctab[1] = cf(-0.5); ctab[2] = cf(-0.125); ctab[3] = cf(-0.0625);
    run(sq(1.0), 4, sq(1.0), sq(1.0), "R4 differentiating set", r);
    run(sq(0.5), 4, sq(0.5), sq(0.5), "R4 differentiating scaled", r);
  endtask

  task automatic t_truncate();
    logic signed [31:0] r;
    clear_coefs();
    ctab[0] = cf(0.5);
    run(32'sd3, 1, sq(1.0), sq(1.0), "R6 positive product", r);
    chk(r == 32'sd1, "R6 1.5 lsb floors to 1", r, 1);
    run(-32'sd3, 1, sq(1.0), sq(1.0), "R6 negative product", r);
    chk(r == -32'sd2, "R6 -1.5 lsb floors to -2", r, -2);
  endtask

  task automatic t_round();
    logic signed [31:0] r;
    clear_coefs();
    ctab[0] = cf(1.0);
    run(32'sd1, 1, sq(0.5), sq(0.5), "R7 round half", r);
    chk(r == 32'sd1, "R7 0.5 lsb rounds to 1", r, 1);
    run(-32'sd1, 1, sq(0.5), sq(0.5), "R7 round neg half", r);
    chk(r == 32'sd0, "R7 -0.5 lsb rounds to 0", r, 0);
    run(32'sd3, 1, sq(0.5), sq(0.5), "R7 round 1.5", r);
    chk(r == 32'sd2, "R7 1.5 lsb rounds to 2", r, 2);
    run(-32'sd3, 1, sq(0.5), sq(0.5), "R7 round -1.5", r);
    chk(r == -32'sd1, "R7 -1.5 lsb rounds to -1", r, -1);
  endtask

  task automatic t_saturate();
    logic signed [31:0] r;
    run(sq(100.0), 1, sq(2.0), sq(2.0), "R8 high clip", r);
    chk(r == 32'sh7FFFFFFF, "R8 clip to max", r, 32'sh7FFFFFFF);
    run(sq(-100.0), 1, sq(2.0), sq(2.0), "R8 low clip", r);
    chk(r == 32'sh80000000, "R8 clip to min", r, 32'sh80000000);
  endtask

  task automatic t_scale_latch();
    logic signed [31:0] r;
    run(sq(1.25), 1, sq(1.0), sq(3.0), "R9 scale change ignored", r);
    chk(r == sq(1.25), "R9 start scale used", r, sq(1.25));
  endtask

  task automatic t_window();
    logic signed [31:0] r;
    for (int i = 0; i < DEP; i++) ctab[i] = cf(0.0625);
    run(sq(0.5), 0, sq(1.0), sq(1.0), "R10 empty window", r);
    chk(r == 32'sd0, "R10 zero terms gives 0", r, 0);
    run(sq(0.25), 40, sq(1.0), sq(1.0), "R10 window clamped to depth", r);
  endtask

  task automatic t_wrap();
    logic signed [31:0] r;
    for (int i = 0; i < DEP; i++) ctab[i] = cf(0.0625 * (i + 1));
    for (int k = 0; k < 6; k++)
      run(sq(0.125 * k - 0.3), DEP, sq(1.0), sq(1.0), "R11 full window after wrap", r);
  endtask

  task automatic t_hold();
    logic signed [31:0] ea, eb;
    clear_coefs();
    ctab[0] = cf(1.0); ctab[1] = cf(1.0); ctab[2] = cf(1.0); ctab[3] = cf(1.0);
    @(negedge clk);
    win_len = LW'(4);
    scale = sq(1.0);
    smp_data = sq(0.5);
    smp_valid = 1'b1;
    @(posedge clk);
    bhist[bn] = sq(0.5);
    bn++;
    ea = model(4, sq(1.0));
    @(negedge clk);
    smp_data = sq(-0.125);
    chk(!smp_ready, "R2 ready low while busy", smp_ready, 0);
    while (!res_valid) @(negedge clk);
    chk(res_data == ea, "R2 first result", res_data, ea);
    @(posedge clk);
    bhist[bn] = sq(-0.125);
    bn++;
    eb = model(4, sq(1.0));
    @(negedge clk);
    smp_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    chk(res_data == eb, "R2 held sample taken later", res_data, eb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp_data = '0;
    win_len = '0;
    scale = '0;
    for (int i = 0; i < DEP; i++) ctab[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_pairing();
    t_truncate();
    t_round();
    t_saturate();
    t_scale_latch();
    t_window();
    t_wrap();
    t_hold();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule